// File: doc/BRIEF.md
# Transfer Address and Count Engine

This block is the per-channel transfer engine of a legacy-style DMA channel. Before each transfer it forms a 24-bit physical address from an 8-bit page value and a 16-bit current address. On each accepted transfer strobe it steps the current address up by one and the remaining count down by one. It serves byte channels and word channels. On a word channel the 16-bit address counts 16-bit words, so it moves up one bit position and the lowest page bit plays no part.

The page never increments. An address run therefore wraps inside its own 64 KiB byte page or 128 KiB word page. The count holds the number of transfers minus one. When a strobe takes it from zero to all ones, the engine raises terminal count for one cycle. It then either reloads its programmed base values (auto-initialise) or masks itself, so that it ignores further strobes until it is programmed again.

The transfer strobe is a plain single-cycle control input with no back-pressure. A strobe is accepted whenever the channel is unmasked and no load is applied in the same cycle; otherwise it is dropped. Bus handshaking belongs to the surrounding controller.

Top module: `xfer_addr_engine`

## Requirements
- R1: After reset the channel is masked, `tc` is 0, `cur_count` is 0x0000 and `phys_addr` is 0x000000.
- R2: A cycle with `load` high copies `base_addr`, `base_count`, `page`, `word_chan` and `auto_init` into the channel and clears the mask. A strobe in the same cycle is dropped.
- R3: With `word_chan` latched as 0, `phys_addr[23:16]` equals the page and `phys_addr[15:0]` equals the current address.
- R4: With `word_chan` latched as 1, `phys_addr[23:17]` equals page bits 7..1, `phys_addr[16:1]` equals the current address and `phys_addr[0]` is 0. Page bit 0 has no effect.
- R5: Each accepted strobe adds one to the current address and subtracts one from the count, both modulo 2^16. An address wrap from 0xFFFF to 0x0000 leaves the page unchanged.
- R6: `tc` is high for exactly the one cycle after the edge at which an accepted strobe finds the count at 0x0000. A loaded count of N-1 therefore gives `tc` after the N-th strobe.
- R7: At terminal count with auto-initialise latched, the current address and count reload from the latched base values and the channel stays unmasked.
- R8: At terminal count without auto-initialise, the channel masks itself. The address still steps by one and the count reads 0xFFFF.
- R9: While masked, strobes do not change `phys_addr`, `cur_count` or `tc`.
- R10: `residue` equals (count + 1) mod 2^16 on a byte channel, and twice that value as a 17-bit number on a word channel. It is 0 after a completed transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Program the channel from the base inputs |
| base_addr | input | 16 | Start address (bytes or words) |
| base_count | input | 16 | Transfers minus one |
| page | input | 8 | Page value, upper physical address bits |
| word_chan | input | 1 | 1 selects a 16-bit word channel |
| auto_init | input | 1 | 1 reloads the base values at terminal count |
| xfer | input | 1 | Transfer strobe, one per transfer |
| phys_addr | output | 24 | Physical address of the next transfer |
| tc | output | 1 | Terminal count pulse |
| masked | output | 1 | Channel mask state |
| cur_count | output | 16 | Current count register |
| residue | output | 17 | Remaining bytes (count + 1, doubled for words) |

## Verification
A byte channel is loaded just below an address wrap with a short count. This shows whether the wrap reaches the page, whether terminal count lands on the right strobe, and whether the channel then masks itself and drops strobes. A word channel is loaded with an odd page and auto-initialise set. This separates a correct shifted mapping from one that uses page bit 0, and a reload from a mask. Idle cycles, a load that coincides with a strobe, and an all-ones count (whose residue wraps to zero) cover the hold, priority and residue corners.

// File: rtl/xae_pkg.sv
package xae_pkg;
  typedef struct packed {
    logic word;
    logic auto_init;
  } xae_mode_t;
endpackage

// File: rtl/xae_step_reg.sv
module xae_step_reg #(
  parameter int W  = 16,
  parameter bit UP = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         step,
  output logic [W-1:0] q
);
  logic [W-1:0] stepped;

  generate
    if (UP) begin : g_up
      assign stepped = q + W'(1);
    end else begin : g_down
      assign stepped = q - W'(1);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (ld)   q <= ld_val;
    else if (step) q <= stepped;
  end
endmodule

// File: rtl/xae_addr_map.sv
module xae_addr_map #(
  parameter int PAGE_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic [PAGE_W-1:0]        page,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     word,
  output logic [PAGE_W+ADDR_W-1:0] phys
);
  always_comb begin
    if (word) phys = {page[PAGE_W-1:1], addr, 1'b0};
    else      phys = {page, addr};
  end
endmodule

// File: rtl/xfer_addr_engine.sv
module xfer_addr_engine
  import xae_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [ADDR_W-1:0]        base_addr,
  input  logic [ADDR_W-1:0]        base_count,
  input  logic [PAGE_W-1:0]        page,
  input  logic                     word_chan,
  input  logic                     auto_init,
  input  logic                     xfer,
  output logic [PAGE_W+ADDR_W-1:0] phys_addr,
  output logic                     tc,
  output logic                     masked,
  output logic [ADDR_W-1:0]        cur_count,
  output logic [ADDR_W:0]          residue
);
  localparam int PHYS_W = PAGE_W + ADDR_W;

  logic [ADDR_W-1:0] base_a_q, base_c_q, addr_q, cnt_q;
  logic [ADDR_W-1:0] a_ld_val, c_ld_val, cnt_p1;
  logic [PAGE_W-1:0] page_q;
  xae_mode_t         mode_q;
  logic              masked_q, tc_q;
  logic              go, underflow, reload, ctr_ld;
  logic [PHYS_W-1:0] phys;

  assign go        = xfer & ~masked_q & ~load;
  assign underflow = go & (cnt_q == '0);
  assign reload    = underflow & mode_q.auto_init;
  assign ctr_ld    = load | reload;
  assign a_ld_val  = load ? base_addr  : base_a_q;
  assign c_ld_val  = load ? base_count : base_c_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_a_q <= '0;
      base_c_q <= '0;
      page_q   <= '0;
      mode_q   <= '0;
      masked_q <= 1'b1;
      tc_q     <= 1'b0;
    end else begin
      tc_q <= underflow;
      if (load) begin
        base_a_q <= base_addr;
        base_c_q <= base_count;
        page_q   <= page;
        mode_q   <= '{word: word_chan, auto_init: auto_init};
        masked_q <= 1'b0;
      end else if (underflow && !mode_q.auto_init) begin
        masked_q <= 1'b1;
      end
    end
  end

  xae_step_reg #(.W(ADDR_W), .UP(1'b1)) u_addr (
    .clk(clk), .rst_n(rst_n), .ld(ctr_ld), .ld_val(a_ld_val),
    .step(go), .q(addr_q)
  );

  xae_step_reg #(.W(ADDR_W), .UP(1'b0)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ld(ctr_ld), .ld_val(c_ld_val),
    .step(go), .q(cnt_q)
  );

  xae_addr_map #(.PAGE_W(PAGE_W), .ADDR_W(ADDR_W)) u_map (
    .page(page_q), .addr(addr_q), .word(mode_q.word), .phys(phys)
  );

  assign cnt_p1    = cnt_q + ADDR_W'(1);
  assign residue   = mode_q.word ? {cnt_p1, 1'b0} : {1'b0, cnt_p1};
  assign phys_addr = phys;
  assign tc        = tc_q;
  assign masked    = masked_q;
  assign cur_count = cnt_q;

  // R2: programming unmasks and sets the start address
  a_r2_load_sets: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!masked_q && addr_q == $past(base_addr) && cnt_q == $past(base_count)));

  // R4: word channel addresses are even
  a_r4_word_even: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q.word |-> !phys_addr[0]);

  // R5: a non-terminal strobe steps both counters
  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cnt_q != '0) |=> (addr_q == $past(addr_q) + ADDR_W'(1)
                             && cnt_q == $past(cnt_q) - ADDR_W'(1)));

  // R7: auto-initialise reload at terminal count
  a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cnt_q == '0 && mode_q.auto_init) |=>
      (addr_q == base_a_q && cnt_q == base_c_q && !masked_q));

  // R8: terminal count without auto-initialise leaves the channel masked
  a_r8_tc_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_q && !mode_q.auto_init) |-> masked_q);

  // R9: masked channel holds its state
  a_r9_masked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (masked_q && !load) |=> ($stable(addr_q) && $stable(cnt_q) && !tc_q));
endmodule

// File: tb/sim_xfer_addr_engine.sv
module sim_xfer_addr_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0, word_chan = 1'b0, auto_init = 1'b0, xfer = 1'b0;
  logic [15:0] base_addr = '0, base_count = '0;
  logic [7:0]  page = '0;
  logic [23:0] phys_addr;
  logic        tc, masked;
  logic [15:0] cur_count;
  logic [16:0] residue;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  xfer_addr_engine u0 (
    .clk(clk), .rst_n(rst_n), .load(load), .base_addr(base_addr),
    .base_count(base_count), .page(page), .word_chan(word_chan),
    .auto_init(auto_init), .xfer(xfer), .phys_addr(phys_addr), .tc(tc),
    .masked(masked), .cur_count(cur_count), .residue(residue)
  );

  typedef struct {
    logic [23:0] phys;
    logic        tc;
    logic        masked;
    logic [15:0] cnt;
    logic [16:0] res;
    string       tag;
  } exp_t;
  exp_t sb[$];

  // reference model state
  logic [15:0] m_addr = 0, m_cnt = 0, m_ba = 0, m_bc = 0;
  logic [7:0]  m_page = 0;
  logic        m_word = 0, m_auto = 0, m_mask = 1, m_tc = 0;

  function automatic exp_t model_out(string tag);
    exp_t e;
    logic [15:0] p1;
    e.phys   = m_word ? {m_page[7:1], m_addr, 1'b0} : {m_page, m_addr};
    e.tc     = m_tc;
    e.masked = m_mask;
    e.cnt    = m_cnt;
    p1       = m_cnt + 16'd1;
    e.res    = m_word ? {p1, 1'b0} : {1'b0, p1};
    e.tag    = tag;
    return e;
  endfunction

  task automatic step(input bit ld, input bit xf, input string tag);
    @(negedge clk);
    load = ld; xfer = xf;
    m_tc = 1'b0;
    if (ld) begin
      m_ba = base_addr; m_bc = base_count; m_page = page;
      m_word = word_chan; m_auto = auto_init; m_mask = 1'b0;
      m_addr = base_addr; m_cnt = base_count;
    end else if (xf && !m_mask) begin
      if (m_cnt == 16'h0000) begin
        m_tc = 1'b1;
        if (m_auto) begin
          m_addr = m_ba; m_cnt = m_bc;
        end else begin
          m_addr = m_addr + 16'd1; m_cnt = 16'hFFFF; m_mask = 1'b1;
        end
      end else begin
        m_addr = m_addr + 16'd1; m_cnt = m_cnt - 16'd1;
      end
    end
    sb.push_back(model_out(tag));
  endtask

  task automatic compare(input exp_t e);
    checks++;
    if (phys_addr !== e.phys || tc !== e.tc || masked !== e.masked ||
        cur_count !== e.cnt || residue !== e.res) begin
      errors++;
      $display("FAIL %s: got addr=%h tc=%b mask=%b cnt=%h res=%h exp addr=%h tc=%b mask=%b cnt=%h res=%h",
               e.tag, phys_addr, tc, masked, cur_count, residue,
               e.phys, e.tc, e.masked, e.cnt, e.res);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk); #2;
      if (sb.size() > 0) compare(sb.pop_front());
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: got running exp finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    compare(model_out("R1 reset"));
    @(negedge clk); rst_n = 1'b1;

    // R9: strobe while masked after reset is ignored
    step(0, 1, "R9 masked after reset");

    // byte channel near wrap, 3 transfers, no auto-init
    base_addr = 16'hFFFE; base_count = 16'd2; page = 8'h12;
    word_chan = 0; auto_init = 0;
    step(1, 0, "R2 R3 load byte");
    step(0, 0, "R3 idle hold");
    step(0, 1, "R5 R10 step 1");
    step(0, 1, "R5 addr wrap in page");
    step(0, 1, "R6 R8 terminal count");
    step(0, 0, "R6 tc one cycle");
    step(0, 1, "R9 masked ignores strobe");
    step(0, 1, "R9 masked ignores again");

    // word channel, odd page, auto-init, 2 transfers
    base_addr = 16'h1234; base_count = 16'd1; page = 8'h35;
    word_chan = 1; auto_init = 1;
    step(1, 0, "R4 load word");
    step(0, 1, "R4 R10 word step");
    step(0, 1, "R6 R7 reload");
    step(0, 1, "R7 runs after reload");
    step(0, 0, "R7 still unmasked");

    // word channel at top of a 128K page
    base_addr = 16'hFFFF; base_count = 16'h0000; page = 8'hFE;
    step(1, 0, "R4 word top");
    step(0, 1, "R5 R7 word wrap tc");

    // load coinciding with a strobe
    base_addr = 16'h0100; base_count = 16'hFFFF; page = 8'hA5;
    word_chan = 0; auto_init = 0;
    step(1, 1, "R2 load beats strobe");
    step(0, 1, "R10 full count residue");
    word_chan = 1;
    step(1, 0, "R10 word full count residue zero");
    step(0, 0, "R10 word idle");

    // count zero, byte, no auto: single transfer
    base_count = 16'h0000; word_chan = 0;
    step(1, 0, "R2 reload single");
    step(0, 1, "R6 R8 single transfer tc");
    step(0, 1, "R9 masked after single");
    step(0, 0, "R6 tc cleared");

    @(negedge clk); load = 0; xfer = 0;
    repeat (3) @(posedge clk);
    #5;
    finish_run();
  end
endmodule